// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets logic running on a single clock read and write an external asynchronous static RAM with a 19-bit address and a byte-wide data path. A client presents a request with a direction flag, an address and, for writes, a data byte. The controller accepts the request in a cycle where it signals ready. It then runs the memory's handshake as a series of whole-clock phases on the active-low chip select, write enable and output enable strobes, and returns read bytes with a one-cycle valid strobe.

Each phase length is a parameter derived from a nanosecond requirement and the clock period. Writes are always controlled by write enable with output enable held high, so the memory never drives during a write. The controller turns on its own data driver only when write enable falls. When one operation is followed by another in the opposite direction, the controller inserts a quiet turnaround gap. During that gap no strobe is active and no driver is enabled, which gives the previous driver time to release the shared bus.

The data bus is brought out as three signals: a driven value, a drive enable and a sampled value. These are joined at the pad.

Top module: `sram_async_ctl`

## Requirements
- R1: During reset and in every cycle where ready is high, mem_cs_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0, and rd_valid is 0 until the first read completes.
- R2: A read holds mem_cs_n=0, mem_oe_n=0 and mem_we_n=1 with a constant mem_addr for ACC access cycles plus one capture cycle. All strobes are back at 1 in the cycle rd_valid is high.
- R3: rd_valid is high for exactly one cycle, T+ACC+1 clock edges after the accepting edge, where T is the turnaround count (0 when no turnaround is needed). rd_data changes only at that edge.
- R4: A write keeps mem_oe_n=1 throughout. It has at least SETUP cycles with mem_cs_n=0, mem_we_n=1 and the driver off. Then come PULSE cycles with mem_we_n=0 and mem_dq_oe=1, where the driver never rises before mem_we_n falls. Then come HOLD cycles with mem_we_n=1, mem_cs_n=0 and the driver still on.
- R5: mem_dq_oe is never 1 while mem_oe_n is 0, so controller and memory never drive the bus in the same cycle.
- R6: When an accepted operation has the opposite direction to the previous one, TA cycles with every strobe at 1 and the driver off come before its first phase. The first operation after reset and same-direction operations get no turnaround.
- R7: A request is taken only in a cycle where ready is 1. ready is 0 from the cycle after that edge until the last phase ends, and returns exactly T+L edges after acceptance. L is ACC+1 for a read and SETUP+PULSE+HOLD for a write.
- R8: Every phase count equals max(1, ceil(t_ns / clock period)). With the defaults at a 10 ns clock this gives SETUP=1, PULSE=1, HOLD=1, ACC=1 and TA=1.
- R9: A read returns the byte most recently written to the same address.
- R10: The address and write byte are latched at acceptance. Changes on req_addr and req_wdata after that edge do not affect the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Operation request, taken when ready is 1 |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Memory address of the request |
| req_wdata | input | DATA_W | Byte to write |
| ready | output | 1 | Controller can accept a request this cycle |
| rd_data | output | DATA_W | Last byte read |
| rd_valid | output | 1 | One-cycle strobe marking new rd_data |
| mem_addr | output | ADDR_W | Address bus to the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_o | output | DATA_W | Value the controller drives onto the data bus |
| mem_dq_oe | output | 1 | Controller data driver enable |
| mem_dq_i | input | DATA_W | Value sampled from the data bus |

## Verification
For each request the bench computes two due cycles from its own phase-count arithmetic: when ready returns (T+L edges after acceptance) and, for a read, when rd_valid and its byte appear (the same edge). It samples exactly at those cycles on the falling edge. The memory model tests strobe ordering and phase lengths as they happen. It only presents valid read data once chip and output enable have been low for the access count, so an early capture shows up as a wrong byte. The gap between operations is measured at the chip-select pin against the turnaround rule.

// File: rtl/sram_async_ctl_pkg.sv
`timescale 1ns/1ps
package sram_async_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_RD_ACCESS  = 3'd1,
    ST_RD_CAPTURE = 3'd2,
    ST_WR_SETUP   = 3'd3,
    ST_WR_PULSE   = 3'd4,
    ST_WR_HOLD    = 3'd5,
    ST_TURNAROUND = 3'd6
  } phase_e;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic drive;
  } bus_ctl_t;

  localparam bus_ctl_t BUS_QUIET = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

  // Whole clock cycles covering need_ps, never fewer than one.
  function automatic int unsigned cycles_for(input int unsigned need_ps,
                                             input int unsigned clk_ps);
    int unsigned n;
    n = (need_ps + clk_ps - 1) / clk_ps;
    return (n == 0) ? 1 : n;
  endfunction

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Counter width able to hold (max_len - 1), at least one bit.
  function automatic int unsigned count_width(input int unsigned max_len);
    int unsigned w;
    w = $clog2(max_len + 1);
    return (w == 0) ? 1 : w;
  endfunction

  // Strobe pattern presented while a phase is active.
  function automatic bus_ctl_t ctl_for_phase(input phase_e ph);
    bus_ctl_t c;
    c = BUS_QUIET;
    case (ph)
      ST_RD_ACCESS, ST_RD_CAPTURE: begin
        c.cs_n = 1'b0;
        c.oe_n = 1'b0;
      end
      ST_WR_SETUP: begin
        c.cs_n = 1'b0;
      end
      ST_WR_PULSE: begin
        c.cs_n  = 1'b0;
        c.we_n  = 1'b0;
        c.drive = 1'b1;
      end
      ST_WR_HOLD: begin
        c.cs_n  = 1'b0;
        c.drive = 1'b1;
      end
      default: c = BUS_QUIET;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sram_async_ctl_timer.sv
`timescale 1ns/1ps
module sram_async_ctl_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

  // R8: a freshly loaded nonzero count cannot expire on the next cycle
  p_load_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> !expired);

endmodule

// File: rtl/sram_async_ctl_seq.sv
`timescale 1ns/1ps
module sram_async_ctl_seq
  import sram_async_ctl_pkg::*;
#(
  parameter int unsigned LEN_SETUP  = 1,
  parameter int unsigned LEN_PULSE  = 1,
  parameter int unsigned LEN_HOLD   = 1,
  parameter int unsigned LEN_ACCESS = 1,
  parameter int unsigned LEN_TURN   = 1,
  parameter int unsigned CNT_W      = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_we,
  input  logic             expired,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             accept,
  output logic             capture,
  output logic             ready,
  output bus_ctl_t         ctl
);

  phase_e   state_q, state_d;
  logic     last_we_q;
  logic     dir_known_q;
  logic     dir_change;
  bus_ctl_t ctl_q;

  function automatic int unsigned len_of(input phase_e ph);
    case (ph)
      ST_RD_ACCESS:  return LEN_ACCESS;
      ST_WR_SETUP:   return LEN_SETUP;
      ST_WR_PULSE:   return LEN_PULSE;
      ST_WR_HOLD:    return LEN_HOLD;
      ST_TURNAROUND: return LEN_TURN;
      default:       return 1;
    endcase
  endfunction

  assign ready      = (state_q == ST_IDLE);
  assign accept     = ready && req;
  assign dir_change = dir_known_q && (last_we_q != req_we);
  assign capture    = (state_q == ST_RD_CAPTURE) && expired;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (dir_change)  state_d = ST_TURNAROUND;
          else if (req_we) state_d = ST_WR_SETUP;
          else             state_d = ST_RD_ACCESS;
        end
      end
      ST_TURNAROUND: if (expired) state_d = last_we_q ? ST_WR_SETUP : ST_RD_ACCESS;
      ST_RD_ACCESS:  if (expired) state_d = ST_RD_CAPTURE;
      ST_RD_CAPTURE: if (expired) state_d = ST_IDLE;
      ST_WR_SETUP:   if (expired) state_d = ST_WR_PULSE;
      ST_WR_PULSE:   if (expired) state_d = ST_WR_HOLD;
      ST_WR_HOLD:    if (expired) state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  assign load     = (state_d != state_q);
  assign load_val = CNT_W'(len_of(state_d) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      ctl_q       <= BUS_QUIET;
      last_we_q   <= 1'b0;
      dir_known_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ctl_q   <= ctl_for_phase(state_d);
      if (accept) begin
        last_we_q   <= req_we;
        dir_known_q <= 1'b1;
      end
    end
  end

  assign ctl = ctl_q;

  p_turn_on_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dir_change) |=> (state_q == ST_TURNAROUND));

  p_no_turn_same_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !dir_change) |=> (state_q != ST_TURNAROUND));

  p_capture_ends_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> ready);

  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);

endmodule

// File: rtl/sram_async_ctl_dpath.sv
`timescale 1ns/1ps
module sram_async_ctl_dpath #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (capture) rdata_q <= mem_dq_i;
      rvalid_q <= capture;
    end
  end

  assign mem_addr = addr_q;
  assign mem_dq_o = wdata_q;
  assign rd_data  = rdata_q;
  assign rd_valid = rvalid_q;

  p_addr_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(mem_addr) && $stable(mem_dq_o)));

  p_valid_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_rdata_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(rd_data));

endmodule

// File: rtl/sram_async_ctl.sv
`timescale 1ns/1ps
module sram_async_ctl
  import sram_async_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CLK_PS    = 10000,
  parameter int unsigned SETUP_PS  = 0,
  parameter int unsigned PULSE_PS  = 8000,
  parameter int unsigned HOLD_PS   = 0,
  parameter int unsigned ACCESS_PS = 10000,
  parameter int unsigned TURN_PS   = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int unsigned LEN_SETUP  = cycles_for(SETUP_PS, CLK_PS);
  localparam int unsigned LEN_PULSE  = cycles_for(PULSE_PS, CLK_PS);
  localparam int unsigned LEN_HOLD   = cycles_for(HOLD_PS, CLK_PS);
  localparam int unsigned LEN_ACCESS = cycles_for(ACCESS_PS, CLK_PS);
  localparam int unsigned LEN_TURN   = cycles_for(TURN_PS, CLK_PS);
  localparam int unsigned LEN_MAX    =
    max_of(max_of(max_of(LEN_SETUP, LEN_PULSE), max_of(LEN_HOLD, LEN_ACCESS)), LEN_TURN);
  localparam int unsigned CNT_W      = count_width(LEN_MAX);

  // Named internal events
  logic             accept;
  logic             capture;
  logic             phase_load;
  logic             phase_expired;
  logic [CNT_W-1:0] phase_len;
  bus_ctl_t         ctl;

  sram_async_ctl_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (phase_load),
    .load_val (phase_len),
    .expired  (phase_expired)
  );

  sram_async_ctl_seq #(
    .LEN_SETUP  (LEN_SETUP),
    .LEN_PULSE  (LEN_PULSE),
    .LEN_HOLD   (LEN_HOLD),
    .LEN_ACCESS (LEN_ACCESS),
    .LEN_TURN   (LEN_TURN),
    .CNT_W      (CNT_W)
  ) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .req_we   (req_we),
    .expired  (phase_expired),
    .load     (phase_load),
    .load_val (phase_len),
    .accept   (accept),
    .capture  (capture),
    .ready    (ready),
    .ctl      (ctl)
  );

  sram_async_ctl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_dq_i  (mem_dq_i),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  assign mem_cs_n  = ctl.cs_n;
  assign mem_we_n  = ctl.we_n;
  assign mem_oe_n  = ctl.oe_n;
  assign mem_dq_oe = ctl.drive;

  p_one_driver_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  p_we_in_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n));

  p_drive_after_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> !mem_we_n);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe));

endmodule

// File: tb/sram_async_ctl_tb_top.sv
`timescale 1ns/1ps
module sram_async_ctl_tb_top;

  localparam int unsigned AW        = 19;
  localparam int unsigned DW        = 8;
  localparam int unsigned CLK_PS    = 10000;
  localparam int unsigned SETUP_PS  = 0;
  localparam int unsigned PULSE_PS  = 8000;
  localparam int unsigned HOLD_PS   = 0;
  localparam int unsigned ACCESS_PS = 10000;
  localparam int unsigned TURN_PS   = 5000;

  // R8: bench's own count: smallest n with n*period >= need, at least 1
  function automatic int unsigned ncyc(input int unsigned ps);
    int unsigned n;
    n = 0;
    while (n * CLK_PS < ps) n++;
    if (n == 0) n = 1;
    return n;
  endfunction

  localparam int unsigned S_C = ncyc(SETUP_PS);
  localparam int unsigned P_C = ncyc(PULSE_PS);
  localparam int unsigned H_C = ncyc(HOLD_PS);
  localparam int unsigned A_C = ncyc(ACCESS_PS);
  localparam int unsigned T_C = ncyc(TURN_PS);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          ready;
  logic [DW-1:0] rd_data;
  logic          rd_valid;
  logic [AW-1:0] mem_addr;
  logic          mem_cs_n, mem_we_n, mem_oe_n;
  logic [DW-1:0] mem_dq_o;
  logic          mem_dq_oe;
  logic [DW-1:0] mem_dq_i = 8'hA5;

  always #5 clk = ~clk;

  sram_async_ctl #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_PS(CLK_PS), .SETUP_PS(SETUP_PS),
    .PULSE_PS(PULSE_PS), .HOLD_PS(HOLD_PS), .ACCESS_PS(ACCESS_PS), .TURN_PS(TURN_PS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .ready(ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  int unsigned cyc = 0;
  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  bit          finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] fill_byte(input logic [AW-1:0] a);
    return a[7:0] ^ {a[18:16], a[12:8]} ^ 8'h5A;
  endfunction

  // ---------------- behavioural memory model ----------------
  logic [7:0]  model_mem [int unsigned];
  int unsigned acc_cnt = 0;
  int unsigned setup_cnt = 0;
  int unsigned pulse_cnt = 0;
  int unsigned gap_cnt = 0;
  logic [7:0]  wr_latch = '0;
  logic        prev_we = 1'b1;
  logic        prev_cs = 1'b1;
  logic        prev_rd = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic        last_op_w = 1'b0;
  logic        op_known = 1'b0;

  always @(posedge clk) begin
    if (rst_n && !mem_cs_n && !mem_oe_n && mem_we_n) acc_cnt <= acc_cnt + 1;
    else acc_cnt <= 0;
  end

  always @(negedge clk) begin
    logic mem_drives;
    logic rd_now;
    logic need_w;
    int unsigned need;
    if (rst_n) begin
      mem_drives = !mem_cs_n && !mem_oe_n && mem_we_n;
      rd_now = mem_drives;
      // R5: controller and memory drivers never overlap
      if (mem_dq_oe) chk(!mem_drives, "R5 bus conflict", mem_drives, 0);
      // R2: read strobes and stable address
      if (!mem_cs_n && !mem_oe_n) chk(mem_we_n, "R2 we during read", mem_we_n, 1);
      if (rd_now && prev_rd) chk(mem_addr == prev_addr, "R2 address moved in read", mem_addr, prev_addr);
      // R4: write sequencing
      if (!mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe) setup_cnt++;
      else if (mem_cs_n) setup_cnt = 0;
      if (!mem_we_n) begin
        chk(mem_oe_n, "R4 oe low in write", mem_oe_n, 1);
        if (prev_we) chk(setup_cnt >= S_C, "R4 setup cycles", setup_cnt, S_C);
        chk(mem_dq_oe, "R4 data driven in pulse", mem_dq_oe, 1);
        pulse_cnt++;
        wr_latch = mem_dq_o;
      end
      if (mem_we_n && !prev_we) begin
        chk(pulse_cnt >= P_C, "R4 pulse cycles", pulse_cnt, P_C);
        chk(mem_dq_oe && !mem_cs_n && mem_dq_o == wr_latch, "R4 hold", mem_dq_oe, 1);
        model_mem[int'(mem_addr)] = wr_latch;
        pulse_cnt = 0;
        setup_cnt = 0;
      end
      // R6: gap before each operation
      if (mem_cs_n) gap_cnt++;
      if (!mem_cs_n && prev_cs) begin
        need_w = mem_oe_n;
        need = 1 + ((op_known && need_w != last_op_w) ? T_C : 0);
        chk(gap_cnt >= need, "R6 turnaround gap", gap_cnt, need);
        last_op_w = need_w;
        op_known = 1'b1;
        gap_cnt = 0;
      end
      // bus value: valid only after the access window has elapsed
      if (mem_drives && acc_cnt >= A_C)
        mem_dq_i <= model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)]
                                                      : fill_byte(mem_addr);
      else
        mem_dq_i <= 8'hEE;
      prev_we = mem_we_n;
      prev_cs = mem_cs_n;
      prev_rd = rd_now;
      prev_addr = mem_addr;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [7:0]    data;
    int unsigned   due;
  } rd_exp_t;

  rd_exp_t     exp_q[$];
  logic [7:0]  sb_mem [int unsigned];
  logic        have_last = 1'b0;
  logic        last_w = 1'b0;

  always @(negedge clk) begin
    rd_exp_t e;
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected rd_valid", 1, 0);
      end else begin
        e = exp_q.pop_front();
        chk(rd_data == e.data, "R9 read data", rd_data, e.data);
        chk(cyc == e.due, "R3 rd_valid cycle", cyc, e.due);
        chk(mem_cs_n && mem_oe_n, "R2 strobes released", {mem_cs_n, mem_oe_n}, 2'b11);
      end
    end
  end

  task automatic run_op(input logic w, input logic [AW-1:0] a, input logic [7:0] d);
    int unsigned acc_edge;
    int unsigned total;
    int unsigned ta;
    rd_exp_t e;
    while (!ready) @(negedge clk);
    ta = (have_last && last_w != w) ? T_C : 0;
    total = ta + (w ? (S_C + P_C + H_C) : (A_C + 1));
    req = 1'b1; req_we = w; req_addr = a; req_wdata = d;
    acc_edge = cyc + 1;
    if (w) begin
      sb_mem[int'(a)] = d;
    end else begin
      e.data = sb_mem.exists(int'(a)) ? sb_mem[int'(a)] : fill_byte(a);
      e.due = acc_edge + total;
      exp_q.push_back(e);
    end
    @(negedge clk);
    req = 1'b0;
    // R10: scramble request inputs after acceptance
    req_addr = ~a;
    req_wdata = ~d;
    req_we = ~w;
    chk(!ready, "R7 busy after accept", ready, 0);
    while (!ready && cyc < acc_edge + total + 50) @(negedge clk);
    chk(cyc == acc_edge + total, "R7 R8 ready return", cyc, acc_edge + total);
    last_w = w;
    have_last = 1'b1;
  endtask

  initial begin
    logic [15:0] lf;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(ready && mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rd_valid,
        "R1 reset outputs", {ready, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, rd_valid}, 6'b111100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready && mem_cs_n && !mem_dq_oe, "R1 after reset", {ready, mem_cs_n, mem_dq_oe}, 3'b110);
    // R4 R10: first writes, no turnaround on first op
    run_op(1'b1, 19'h00010, 8'h3C);
    run_op(1'b1, 19'h00011, 8'hC3);
    // R6 R9: direction change to read
    run_op(1'b0, 19'h00010, 8'h00);
    run_op(1'b0, 19'h00011, 8'h00);
    // R9: never-written location returns the memory's content
    run_op(1'b0, 19'h12345, 8'h00);
    // boundary address
    run_op(1'b1, 19'h7FFFF, 8'hA7);
    run_op(1'b0, 19'h7FFFF, 8'h00);
    run_op(1'b1, 19'h00000, 8'hFF);
    run_op(1'b0, 19'h00000, 8'h00);
    // mixed traffic
    lf = 16'hACE1;
    for (int i = 0; i < 40; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      run_op(lf[0], {14'h0, lf[5:1]}, lf[15:8]);
    end
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R3 reads outstanding", exp_q.size(), 0);
    chk(ready && mem_cs_n && !mem_dq_oe, "R1 idle at end", {ready, mem_cs_n, mem_dq_oe}, 3'b110);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  always @(posedge clk) begin
    if (cyc == 20000 && !finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule